// File: doc/BRIEF.md
# VCO Calibration and Fast-Lock Sequencer

This controller steps a frequency synthesizer through the timed phases that follow every write of a new divider value. The first phase is VCO band calibration. While it lasts, the charge pump is held in high impedance and the VCO tune input is switched to an internal reference. If fast lock was enabled when the write arrived, a second timed phase follows. In that phase the charge pump runs from a separate, larger current code. The sequencer then settles in normal operation. Both phase timers advance only on a one-cycle strobe that marks each phase-detector comparison. The controller does not perform the band search and does not model the analog switches.

The calibration length follows an exponential encoding of a 4-bit field: the length is 11 times two raised to that field. The fast-lock length follows a linear encoding of another 4-bit field: three plus four times the field. Both lengths are captured when the sequence starts. A separate control bit can force the charge pump to high impedance at any time.

Top module: `vco_cal_seq`

## Requirements
- R1: After reset `busy` and `tune_ref` are 0, `cp_code` equals `cp_norm`, and `cp_hiz` equals `hiz_force`.
- R2: A `div_wr` pulse while idle raises `busy`, `tune_ref` and `cp_hiz` from the next cycle on.
- R3: Calibration lasts exactly 11·2^`cal_exp` strobes of `pfd_tick`. Clock cycles without the strobe do not advance it.
- R4: A `cal_exp` value of 11 or more is treated as 10, which gives 11264 strobes.
- R5: When `fast_en` is 1 at the trigger, a fast-lock phase follows calibration. It lasts 3 + 4·`fast_len` strobes. During it `busy` is 1, `tune_ref` is 0, `cp_code` equals `cp_fast`, and `cp_hiz` equals `hiz_force`.
- R6: When `fast_en` is 0 at the trigger, the block enters normal operation directly after calibration.
- R7: In normal operation `busy` and `tune_ref` are 0 and `cp_code` equals `cp_norm`.
- R8: `hiz_force` = 1 drives `cp_hiz` to 1 in every phase.
- R9: A `div_wr` pulse while `busy` is 1 is ignored: neither phase length changes.
- R10: `soft_rst` returns the block to normal operation in the next cycle. It takes priority over a `div_wr` in the same cycle.
- R11: `cal_exp`, `fast_en` and `fast_len` are captured at the trigger. Changing them during a sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_tick | input | 1 | One-cycle strobe per phase comparison |
| div_wr | input | 1 | Divider-register write strobe (sequence trigger) |
| soft_rst | input | 1 | Synchronous return to normal operation |
| cal_exp | input | 4 | Calibration length exponent |
| fast_en | input | 1 | Enable fast-lock phase |
| fast_len | input | 4 | Fast-lock length field |
| cp_norm | input | 3 | Charge-pump code for normal operation |
| cp_fast | input | 3 | Charge-pump code for fast lock |
| hiz_force | input | 1 | Force charge pump to high impedance |
| cp_code | output | 3 | Selected charge-pump current code |
| cp_hiz | output | 1 | Charge-pump high-impedance control |
| tune_ref | output | 1 | 1 = tune input tied to internal reference |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions assume that `pfd_tick`, `div_wr` and `soft_rst` are clean one-cycle-sampled levels, synchronous to `clk`. They also assume that the settings change only between clock edges. The stimulus drives every input on the falling edge. It raises the strobe on a fixed cadence counted from the trigger, so each expected phase length is the strobe count times that cadence. Retrigger and setting changes are injected only in the middle of a running calibration, where the captured values must govern.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAL  = 2'd1,
    PH_FAST = 2'd2
  } phase_e;
endpackage

// File: rtl/calseq_cfg.sv
module calseq_cfg #(
  parameter int EXP_W    = 4,
  parameter int EXP_MAX  = 10,
  parameter int CAL_UNIT = 11,
  parameter int LIN_W    = 4,
  parameter int LIN_BASE = 3,
  parameter int LIN_STEP = 4,
  parameter int TMR_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [EXP_W-1:0] cal_exp,
  input  logic             fast_en,
  input  logic [LIN_W-1:0] fast_len,
  output logic [TMR_W-1:0] cal_len_q,
  output logic [TMR_W-1:0] fast_len_q,
  output logic             fast_en_q
);
  localparam int CAL_LEN_MAX  = CAL_UNIT << EXP_MAX;
  localparam int FAST_LEN_MAX = LIN_BASE + LIN_STEP * ((1 << LIN_W) - 1);

  logic [EXP_W-1:0] exp_c;
  logic [TMR_W-1:0] cal_len_d;
  logic [TMR_W-1:0] fast_len_d;

  always_comb begin
    exp_c      = (cal_exp > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : cal_exp;
    cal_len_d  = TMR_W'(CAL_UNIT) << exp_c;
    fast_len_d = TMR_W'(LIN_BASE) + TMR_W'(LIN_STEP) * TMR_W'(fast_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_len_q  <= TMR_W'(CAL_UNIT);
      fast_len_q <= TMR_W'(LIN_BASE);
      fast_en_q  <= 1'b0;
    end else if (capture) begin
      cal_len_q  <= cal_len_d;
      fast_len_q <= fast_len_d;
      fast_en_q  <= fast_en;
    end
  end

  // R4
  cal_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_len_q >= TMR_W'(CAL_UNIT)) && (cal_len_q <= TMR_W'(CAL_LEN_MAX)));

  // R5
  fast_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_len_q >= TMR_W'(LIN_BASE)) && (fast_len_q <= TMR_W'(FAST_LEN_MAX)));
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer #(
  parameter int TMR_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [TMR_W-1:0] limit,
  output logic             last
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    last   = run && tick && (cnt_q == limit - TMR_W'(1));
    cnt_en = clr || (run && tick);
    if (clr || last) cnt_d = '0;
    else             cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

  // R3
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
  import calseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   div_wr,
  input  logic   soft_rst,
  input  logic   last,
  input  logic   fast_en_q,
  output phase_e phase,
  output logic   start
);
  phase_e phase_d;

  always_comb begin
    start   = (phase == PH_IDLE) && div_wr && !soft_rst;
    phase_d = phase;
    if (soft_rst) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (div_wr) phase_d = PH_CAL;
        PH_CAL:  if (last)   phase_d = fast_en_q ? PH_FAST : PH_IDLE;
        PH_FAST: if (last)   phase_d = PH_IDLE;
        default:             phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  // R2
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && div_wr && !soft_rst) |=> (phase == PH_CAL));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !soft_rst && !last) |=> $stable(phase));

  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (phase == PH_IDLE));

  // R6
  fast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CAL) && last && !soft_rst && !fast_en_q) |=> (phase == PH_IDLE));
endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq
  import calseq_pkg::*;
#(
  parameter int EXP_W    = 4,
  parameter int EXP_MAX  = 10,
  parameter int CAL_UNIT = 11,
  parameter int LIN_W    = 4,
  parameter int LIN_BASE = 3,
  parameter int LIN_STEP = 4,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfd_tick,
  input  logic              div_wr,
  input  logic              soft_rst,
  input  logic [EXP_W-1:0]  cal_exp,
  input  logic              fast_en,
  input  logic [LIN_W-1:0]  fast_len,
  input  logic [CODE_W-1:0] cp_norm,
  input  logic [CODE_W-1:0] cp_fast,
  input  logic              hiz_force,
  output logic [CODE_W-1:0] cp_code,
  output logic              cp_hiz,
  output logic              tune_ref,
  output logic              busy
);
  localparam int CAL_LEN_MAX  = CAL_UNIT << EXP_MAX;
  localparam int FAST_LEN_MAX = LIN_BASE + LIN_STEP * ((1 << LIN_W) - 1);
  localparam int LEN_MAX      = (CAL_LEN_MAX > FAST_LEN_MAX) ? CAL_LEN_MAX : FAST_LEN_MAX;
  localparam int TMR_W        = $clog2(LEN_MAX + 1);

  phase_e           phase;
  logic             start;
  logic             last;
  logic             fast_en_q;
  logic [TMR_W-1:0] cal_len_q;
  logic [TMR_W-1:0] fast_len_q;
  logic [TMR_W-1:0] limit;
  logic             run;

  calseq_cfg #(
    .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .CAL_UNIT(CAL_UNIT),
    .LIN_W(LIN_W), .LIN_BASE(LIN_BASE), .LIN_STEP(LIN_STEP), .TMR_W(TMR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(start),
    .cal_exp(cal_exp), .fast_en(fast_en), .fast_len(fast_len),
    .cal_len_q(cal_len_q), .fast_len_q(fast_len_q), .fast_en_q(fast_en_q)
  );

  calseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .soft_rst(soft_rst),
    .last(last), .fast_en_q(fast_en_q), .phase(phase), .start(start)
  );

  always_comb begin
    run   = (phase != PH_IDLE) && !soft_rst;
    limit = (phase == PH_FAST) ? fast_len_q : cal_len_q;
  end

  calseq_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(start || soft_rst), .run(run),
    .tick(pfd_tick), .limit(limit), .last(last)
  );

  always_comb begin
    busy     = (phase != PH_IDLE);
    tune_ref = (phase == PH_CAL);
    cp_hiz   = hiz_force || (phase == PH_CAL);
    cp_code  = (phase == PH_FAST) ? cp_fast : cp_norm;
  end

  // R8
  hiz_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_force |-> cp_hiz);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ($stable(cal_len_q) && $stable(fast_len_q) && $stable(fast_en_q)));
endmodule

// File: tb/vco_cal_seq_test.sv
module vco_cal_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pfd_tick, div_wr, soft_rst, fast_en, hiz_force;
  logic [3:0] cal_exp, fast_len;
  logic [2:0] cp_norm, cp_fast;
  logic [2:0] cp_code;
  logic       cp_hiz, tune_ref, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vco_cal_seq uut (
    .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .div_wr(div_wr),
    .soft_rst(soft_rst), .cal_exp(cal_exp), .fast_en(fast_en),
    .fast_len(fast_len), .cp_norm(cp_norm), .cp_fast(cp_fast),
    .hiz_force(hiz_force), .cp_code(cp_code), .cp_hiz(cp_hiz),
    .tune_ref(tune_ref), .busy(busy)
  );

  // Vector: [15:12] cal_exp, [11] fast_en, [10:7] fast_len, [6:4] strobe cadence
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd0,  1'b1, 4'd0,  3'd1, 4'd0},
    {4'd1,  1'b1, 4'd15, 3'd2, 4'd0},
    {4'd3,  1'b0, 4'd5,  3'd1, 4'd0},
    {4'd10, 1'b1, 4'd1,  3'd1, 4'd0},
    {4'd12, 1'b0, 4'd0,  3'd1, 4'd0},
    {4'd15, 1'b1, 4'd2,  3'd1, 4'd0},
    {4'd2,  1'b1, 4'd7,  3'd3, 4'd0}
  };

  function automatic int exp_cal(int c, int d);
    return 11 * (1 << ((c > 10) ? 10 : c)) * d;
  endfunction

  function automatic int exp_fast(int fen, int f, int d);
    return (fen != 0) ? (3 + 4 * f) * d : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Trigger a sequence and measure its phases. poke_n > 0 injects a retrigger
  // with changed settings at that cycle after the trigger.
  task automatic run_seq(input int c, input int fen, input int f, input int d,
                         input int poke_n, output int cal_n, output int fast_n,
                         output int bad);
    cal_n = 0; fast_n = 0; bad = 0;
    @(negedge clk);
    cal_exp = 4'(c); fast_en = fen[0]; fast_len = 4'(f);
    div_wr = 1'b1; pfd_tick = 1'b0;
    for (int n = 1; n < 20000; n++) begin
      @(negedge clk);
      if (tune_ref) begin
        cal_n++;
        if (!cp_hiz || !busy) bad++;
      end else if (busy) begin
        fast_n++;
        if (cp_code != cp_fast || cp_hiz != hiz_force) bad++;
      end else begin
        break;
      end
      div_wr = (n == poke_n);
      if (n == poke_n) begin
        cal_exp = 4'd0; fast_len = 4'd0; fast_en = ~fast_en;
      end
      pfd_tick = ((n % d) == 0);
    end
    pfd_tick = 1'b0;
    div_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cal_n, fast_n, bad;
    rst_n = 1'b0; pfd_tick = 0; div_wr = 0; soft_rst = 0; fast_en = 0;
    hiz_force = 0; cal_exp = 0; fast_len = 0; cp_norm = 3'd2; cp_fast = 3'd6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !tune_ref, "R1 busy/tune_ref", {busy, tune_ref}, 0);
    chk(cp_code == cp_norm, "R1 cp_code", cp_code, cp_norm);
    chk(cp_hiz == 1'b0, "R1 cp_hiz", cp_hiz, 0);

    // Table of vectors: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      int c, fen, f, d;
      c = VEC[i][15:12]; fen = VEC[i][11]; f = VEC[i][10:7]; d = VEC[i][6:4];
      cp_norm = 3'(i); cp_fast = ~3'(i);
      run_seq(c, fen, f, d, 0, cal_n, fast_n, bad);
      chk(cal_n == exp_cal(c, d), "R3/R4 calibration length", cal_n, exp_cal(c, d));
      chk(fast_n == exp_fast(fen, f, d), "R5/R6 fast-lock length", fast_n, exp_fast(fen, f, d));
      chk(bad == 0, "R2/R5 phase outputs", bad, 0);
      chk(cp_code == cp_norm && !busy && !tune_ref, "R7 normal outputs", cp_code, cp_norm);
    end

    // R9 and R11: retrigger with new settings mid-calibration is ignored
    cp_norm = 3'd1; cp_fast = 3'd5;
    run_seq(2, 1, 3, 1, 10, cal_n, fast_n, bad);
    chk(cal_n == 44, "R9 retrigger calibration length", cal_n, 44);
    chk(fast_n == 15, "R11 captured fast length", fast_n, 15);

    // R8 forced high impedance in every phase
    hiz_force = 1'b1;
    run_seq(0, 1, 2, 1, 0, cal_n, fast_n, bad);
    chk(bad == 0 && fast_n == 11, "R8 fast phase hiz", bad, 0);
    chk(cp_hiz == 1'b1, "R8 normal hiz forced", cp_hiz, 1);
    hiz_force = 1'b0;
    @(negedge clk);
    chk(cp_hiz == 1'b0, "R8 hiz released", cp_hiz, 0);

    // R10 soft reset mid-calibration, together with a retrigger
    cal_exp = 4'd3; fast_en = 1'b1; fast_len = 4'd4;
    div_wr = 1'b1; pfd_tick = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
    chk(tune_ref == 1'b1, "R2 calibration entered", tune_ref, 1);
    repeat (5) @(negedge clk);
    soft_rst = 1'b1; div_wr = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; div_wr = 1'b0; pfd_tick = 1'b0;
    chk(!busy && !tune_ref, "R10 soft reset to normal", {busy, tune_ref}, 0);
    chk(cp_code == cp_norm, "R10 cp_code normal", cp_code, cp_norm);
    // R10 soft reset wins over a trigger while idle
    soft_rst = 1'b1; div_wr = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; div_wr = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 soft reset beats trigger", busy, 0);
    // Clean sequence after soft reset
    run_seq(1, 0, 0, 2, 0, cal_n, fast_n, bad);
    chk(cal_n == 44 && fast_n == 0, "R3/R10 sequence after soft reset", cal_n, 44);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule